// File: doc/BRIEF.md
# JTAG Programming Status Flag Pins

This block drives two sideband pins for in-system programming of on-chip flash over a JTAG port. One pin is a ready/busy flag. The other is a sticky, active-low error flag. With these pins the programming host can poll progress directly and does not have to shift status out through the scan chain.

The TAP controller decodes the instructions and passes them in as single-cycle strobes:

- enable the extension pins;
- clear the error;
- select the drive mode;
- leave the programming mode (ISC_DISABLE).

The flash engine supplies per-source busy levels and per-source failure pulses. A chip reset input interacts with the JTAG logic in one of two ways, chosen by a select input:

- **Pins dedicated by a non-volatile setting:** chip reset has no effect on JTAG activity.
- **Pins enabled by a runtime enable register:** chip reset blocks JTAG activity and clears the configuration. The `jtag_active` output tells the rest of the chip whether JTAG commands are being honoured.

The error flag latches low on a failure. It stays low until an explicit clear command. It also releases on the first chip reset that follows an ISC_DISABLE command, which arms a one-shot release.

Either flag can be driven push-pull. Either can also be driven open-drain, where the pad is pulled low only while the flag is low.

Top module: `isp_flag_pins`

## Requirements
- R1: After `rst_n` is released, both pins are inactive (`stat_oe`=0, `err_oe`=0, `stat_o`=0, `err_o`=0). Drive mode is push-pull, the error flag reads "no error" (1), the status flag reads ready (1), and no release is armed.
- R2: `stat_oe` and `err_oe` stay 0 until a `cmd_ext_on` strobe is accepted. From the next cycle on, both pins are driven according to the drive mode.
- R3: The status flag is 1 when every bit of `busy_i` is 0. It becomes 0 one cycle after any `busy_i` bit is 1, whichever source it is. It returns to 1 one cycle after all bits drop.
- R4: Any `fail_i` bit at 1 forces the error flag to 0 on the next cycle. The flag stays 0 after the failure input drops.
- R5: An accepted `cmd_err_clr` sets the error flag back to 1 on the next cycle. A `fail_i` bit in the same cycle wins, and the flag stays 0.
- R6: A `chip_rst` pulse with no armed release leaves the error flag unchanged.
- R7: An accepted `cmd_isc_off` arms a release. The next `chip_rst` pulse sets the error flag to 1, unless a failure arrives in the same cycle, and it consumes the arming. A later `chip_rst` without a new `cmd_isc_off` has no effect on the flag.
- R8: An accepted `cmd_drv_set` loads the drive mode from `cmd_drv_od` (1 = open-drain, 0 = push-pull).
  - In push-pull mode, with the pins enabled, each pin has oe=1 and o equal to its flag.
  - In open-drain mode, each pin has o=0 and oe equal to the inverse of its flag.
- R9: When `pin_src_nvm`=1, `jtag_active` is 1 at all times, `chip_rst` leaves pin enable and drive mode unchanged, and commands are accepted during `chip_rst`.
- R10: When `pin_src_nvm`=0, `jtag_active` equals `jtag_reg_en` AND NOT `chip_rst`. A `chip_rst` clears pin enable and returns the drive mode to push-pull on the next cycle. Commands strobed during `chip_rst` are not accepted.
- R11: While `jtag_active` is 0, every command strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| chip_rst | input | 1 | Chip reset pulse, active high, synchronous |
| pin_src_nvm | input | 1 | 1: JTAG pins dedicated by non-volatile setting; 0: enabled by runtime register |
| jtag_reg_en | input | 1 | Runtime JTAG enable register bit |
| cmd_ext_on | input | 1 | Strobe: enable the status/error pins |
| cmd_err_clr | input | 1 | Strobe: clear the error flag |
| cmd_drv_set | input | 1 | Strobe: load drive mode from `cmd_drv_od` |
| cmd_drv_od | input | 1 | Drive mode value for `cmd_drv_set` (1 open-drain) |
| cmd_isc_off | input | 1 | Strobe: ISC_DISABLE executed, arms reset release |
| busy_i | input | N_BUSY | Per-source program/erase/write busy levels |
| fail_i | input | N_FAIL | Per-source failure pulses |
| stat_o | output | 1 | Status pin data |
| stat_oe | output | 1 | Status pin output enable |
| err_o | output | 1 | Error pin data |
| err_oe | output | 1 | Error pin output enable |
| jtag_active | output | 1 | JTAG commands currently honoured |

## Verification
The bench builds the block with its default parameters:

- `N_BUSY`=3 covers primary program/erase, secondary program/erase and secondary data write.
- `N_FAIL`=2 covers erase failure and program failure.

With these widths, every busy source can be walked individually to show that each one alone pulls the status flag low. Both failure sources are exercised, including a failure in the same cycle as a clear command.

Both pin-source modes are driven. This makes the one-shot release and the reset-gated configuration clearing visible at the pins.

// File: rtl/isp_flag_pkg.sv
package isp_flag_pkg;

  typedef enum logic {
    DRV_PUSH_PULL  = 1'b0,
    DRV_OPEN_DRAIN = 1'b1
  } drv_mode_e;

  typedef struct packed {
    logic ext_on;
    logic err_clr;
    logic drv_set;
    logic drv_val;
    logic isc_off;
  } cmd_t;

  localparam int FLAG_PINS = 2;
  localparam int PIN_STAT  = 0;
  localparam int PIN_ERR   = 1;

endpackage

// File: rtl/isp_cmd_gate.sv
module isp_cmd_gate
  import isp_flag_pkg::*;
(
  input  logic pin_src_nvm,
  input  logic jtag_reg_en,
  input  logic chip_rst,
  input  cmd_t cmd_raw,
  output logic jtag_active,
  output cmd_t cmd_ok
);

  always_comb begin
    if (pin_src_nvm) jtag_active = 1'b1;
    else             jtag_active = jtag_reg_en & ~chip_rst;
  end

  always_comb begin
    cmd_ok         = cmd_raw;
    cmd_ok.ext_on  = cmd_raw.ext_on  & jtag_active;
    cmd_ok.err_clr = cmd_raw.err_clr & jtag_active;
    cmd_ok.drv_set = cmd_raw.drv_set & jtag_active;
    cmd_ok.isc_off = cmd_raw.isc_off & jtag_active;
  end

endmodule

// File: rtl/isp_flag_core.sv
module isp_flag_core
  import isp_flag_pkg::*;
#(
  parameter int N_BUSY = 3,
  parameter int N_FAIL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_rst,
  input  logic              pin_src_nvm,
  input  cmd_t              cmd_ok,
  input  logic [N_BUSY-1:0] busy_i,
  input  logic [N_FAIL-1:0] fail_i,
  output logic              ext_en,
  output drv_mode_e         drv_mode,
  output logic              stat_flag,
  output logic              err_flag,
  output logic              armed
);

  logic      any_busy, any_fail, cfg_wipe;
  logic      ext_nx, stat_nx, err_nx, armed_nx;
  drv_mode_e drv_nx;
  logic      ext_ce, drv_ce, err_ce, armed_ce;

  always_comb begin
    any_busy = |busy_i;
    any_fail = |fail_i;
    cfg_wipe = chip_rst & ~pin_src_nvm;
  end

  // configuration next state
  always_comb begin
    ext_ce = cfg_wipe | cmd_ok.ext_on;
    ext_nx = ~cfg_wipe;
    drv_ce = cfg_wipe | cmd_ok.drv_set;
    if (cfg_wipe)            drv_nx = DRV_PUSH_PULL;
    else if (cmd_ok.drv_val) drv_nx = DRV_OPEN_DRAIN;
    else                     drv_nx = DRV_PUSH_PULL;
  end

  // flag next state
  always_comb begin
    stat_nx  = ~any_busy;
    armed_ce = cmd_ok.isc_off | (chip_rst & armed);
    armed_nx = cmd_ok.isc_off;
    err_ce   = any_fail | cmd_ok.err_clr | (chip_rst & armed);
    err_nx   = ~any_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en    <= 1'b0;
      drv_mode  <= DRV_PUSH_PULL;
      stat_flag <= 1'b1;
      err_flag  <= 1'b1;
      armed     <= 1'b0;
    end else begin
      stat_flag <= stat_nx;
      if (ext_ce)   ext_en   <= ext_nx;
      if (drv_ce)   drv_mode <= drv_nx;
      if (err_ce)   err_flag <= err_nx;
      if (armed_ce) armed    <= armed_nx;
    end
  end

endmodule

// File: rtl/isp_pad_drive.sv
module isp_pad_drive
  import isp_flag_pkg::*;
#(
  parameter int PINS = FLAG_PINS
) (
  input  logic [PINS-1:0] flag_i,
  input  logic            ext_en,
  input  drv_mode_e       drv_mode,
  output logic [PINS-1:0] pad_o,
  output logic [PINS-1:0] pad_oe
);

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    always_comb begin
      if (!ext_en) begin
        pad_o[g]  = 1'b0;
        pad_oe[g] = 1'b0;
      end else if (drv_mode == DRV_OPEN_DRAIN) begin
        pad_o[g]  = 1'b0;
        pad_oe[g] = ~flag_i[g];
      end else begin
        pad_o[g]  = flag_i[g];
        pad_oe[g] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/isp_flag_pins.sv
module isp_flag_pins
  import isp_flag_pkg::*;
#(
  parameter int N_BUSY = 3,
  parameter int N_FAIL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_rst,
  input  logic              pin_src_nvm,
  input  logic              jtag_reg_en,
  input  logic              cmd_ext_on,
  input  logic              cmd_err_clr,
  input  logic              cmd_drv_set,
  input  logic              cmd_drv_od,
  input  logic              cmd_isc_off,
  input  logic [N_BUSY-1:0] busy_i,
  input  logic [N_FAIL-1:0] fail_i,
  output logic              stat_o,
  output logic              stat_oe,
  output logic              err_o,
  output logic              err_oe,
  output logic              jtag_active
);

  cmd_t      cmd_raw, cmd_ok;
  logic      ext_en, stat_flag, err_flag, armed;
  drv_mode_e drv_mode;
  logic [FLAG_PINS-1:0] flags, pad_o, pad_oe;

  always_comb begin
    cmd_raw.ext_on  = cmd_ext_on;
    cmd_raw.err_clr = cmd_err_clr;
    cmd_raw.drv_set = cmd_drv_set;
    cmd_raw.drv_val = cmd_drv_od;
    cmd_raw.isc_off = cmd_isc_off;
  end

  isp_cmd_gate u_gate (
    .pin_src_nvm (pin_src_nvm),
    .jtag_reg_en (jtag_reg_en),
    .chip_rst    (chip_rst),
    .cmd_raw     (cmd_raw),
    .jtag_active (jtag_active),
    .cmd_ok      (cmd_ok)
  );

  isp_flag_core #(.N_BUSY(N_BUSY), .N_FAIL(N_FAIL)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_rst    (chip_rst),
    .pin_src_nvm (pin_src_nvm),
    .cmd_ok      (cmd_ok),
    .busy_i      (busy_i),
    .fail_i      (fail_i),
    .ext_en      (ext_en),
    .drv_mode    (drv_mode),
    .stat_flag   (stat_flag),
    .err_flag    (err_flag),
    .armed       (armed)
  );

  always_comb begin
    flags[PIN_STAT] = stat_flag;
    flags[PIN_ERR]  = err_flag;
  end

  isp_pad_drive #(.PINS(FLAG_PINS)) u_pads (
    .flag_i   (flags),
    .ext_en   (ext_en),
    .drv_mode (drv_mode),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe)
  );

  always_comb begin
    stat_o  = pad_o[PIN_STAT];
    stat_oe = pad_oe[PIN_STAT];
    err_o   = pad_o[PIN_ERR];
    err_oe  = pad_oe[PIN_ERR];
  end

endmodule

// File: rtl/isp_flag_chk.sv
module isp_flag_chk
  import isp_flag_pkg::*;
#(
  parameter int N_BUSY = 3,
  parameter int N_FAIL = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_rst,
  input logic              pin_src_nvm,
  input logic              cmd_err_clr,
  input logic              cmd_isc_off,
  input logic [N_BUSY-1:0] busy_i,
  input logic [N_FAIL-1:0] fail_i,
  input logic              stat_o,
  input logic              stat_oe,
  input logic              err_o,
  input logic              err_oe,
  input logic              jtag_active,
  input logic              ext_en,
  input drv_mode_e         drv_mode,
  input logic              stat_flag,
  input logic              err_flag,
  input logic              armed
);

  p_quiet_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> (!stat_oe && !err_oe && !stat_o && !err_o));

  p_busy_lowers_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|busy_i) |=> !stat_flag);

  p_fail_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|fail_i) |=> !err_flag);

  p_plain_reset_holds_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst && !armed && fail_i == '0 && !cmd_err_clr) |=> $stable(err_flag));

  p_armed_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst && armed && fail_i == '0 && !cmd_isc_off) |=> (err_flag && !armed));

  p_open_drain_low_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && drv_mode == DRV_OPEN_DRAIN) |-> (!stat_o && !err_o));

  p_nvm_always_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_src_nvm |-> jtag_active);

  p_reg_reset_wipes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_src_nvm && chip_rst) |=> (!ext_en && drv_mode == DRV_PUSH_PULL));

endmodule

bind isp_flag_pins isp_flag_chk #(.N_BUSY(N_BUSY), .N_FAIL(N_FAIL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chip_rst    (chip_rst),
  .pin_src_nvm (pin_src_nvm),
  .cmd_err_clr (cmd_err_clr),
  .cmd_isc_off (cmd_isc_off),
  .busy_i      (busy_i),
  .fail_i      (fail_i),
  .stat_o      (stat_o),
  .stat_oe     (stat_oe),
  .err_o       (err_o),
  .err_oe      (err_oe),
  .jtag_active (jtag_active),
  .ext_en      (ext_en),
  .drv_mode    (drv_mode),
  .stat_flag   (stat_flag),
  .err_flag    (err_flag),
  .armed       (armed)
);

// File: tb/isp_flag_pins_bench.sv
module isp_flag_pins_bench;

  localparam int N_BUSY = 3;
  localparam int N_FAIL = 2;

  logic clk = 1'b0;
  logic rst_n, chip_rst, pin_src_nvm, jtag_reg_en;
  logic cmd_ext_on, cmd_err_clr, cmd_drv_set, cmd_drv_od, cmd_isc_off;
  logic [N_BUSY-1:0] busy_i;
  logic [N_FAIL-1:0] fail_i;
  logic stat_o, stat_oe, err_o, err_oe, jtag_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  isp_flag_pins #(.N_BUSY(N_BUSY), .N_FAIL(N_FAIL)) u_isp_flag_pins (
    .clk(clk), .rst_n(rst_n), .chip_rst(chip_rst), .pin_src_nvm(pin_src_nvm),
    .jtag_reg_en(jtag_reg_en), .cmd_ext_on(cmd_ext_on), .cmd_err_clr(cmd_err_clr),
    .cmd_drv_set(cmd_drv_set), .cmd_drv_od(cmd_drv_od), .cmd_isc_off(cmd_isc_off),
    .busy_i(busy_i), .fail_i(fail_i), .stat_o(stat_o), .stat_oe(stat_oe),
    .err_o(err_o), .err_oe(err_oe), .jtag_active(jtag_active)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // pins packed as {stat_oe, stat_o, err_oe, err_o}
  function automatic logic [7:0] pins();
    return {4'h0, stat_oe, stat_o, err_oe, err_o};
  endfunction

  task automatic pulse_ext();  cmd_ext_on  = 1'b1; tick(); cmd_ext_on  = 1'b0; endtask
  task automatic pulse_clr();  cmd_err_clr = 1'b1; tick(); cmd_err_clr = 1'b0; endtask
  task automatic pulse_isc();  cmd_isc_off = 1'b1; tick(); cmd_isc_off = 1'b0; endtask
  task automatic pulse_rst();  chip_rst    = 1'b1; tick(); chip_rst    = 1'b0; endtask
  task automatic pulse_fail(input int i); fail_i[i] = 1'b1; tick(); fail_i = '0; endtask
  task automatic set_drv(input logic od);
    cmd_drv_set = 1'b1; cmd_drv_od = od; tick(); cmd_drv_set = 1'b0; cmd_drv_od = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chip_rst = 1'b0; pin_src_nvm = 1'b1; jtag_reg_en = 1'b0;
    cmd_ext_on = 0; cmd_err_clr = 0; cmd_drv_set = 0; cmd_drv_od = 0; cmd_isc_off = 0;
    busy_i = '0; fail_i = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 pins idle after reset", pins(), 8'h0);
    chk("R9 active in nvm mode", {7'd0, jtag_active}, 8'd1);
  endtask

  task automatic t_enable();
    busy_i = 3'b001; tick(); busy_i = '0;
    chk("R2 pins off before enable", pins(), 8'h0);
    pulse_ext();
    chk("R2 R1 push-pull ready no-error", pins(), 8'b1111);
  endtask

  task automatic t_status();
    for (int i = 0; i < N_BUSY; i++) begin
      busy_i = '0; busy_i[i] = 1'b1; tick();
      chk($sformatf("R3 busy source %0d lowers status", i), {7'd0, stat_o}, 8'd0);
      busy_i = '0; tick();
      chk($sformatf("R3 status back to ready %0d", i), {7'd0, stat_o}, 8'd1);
    end
    busy_i = 3'b110; tick(); busy_i = '0;
    chk("R3 several sources", {7'd0, stat_o}, 8'd0);
    tick();
  endtask

  task automatic t_error();
    pulse_fail(0);
    chk("R4 erase fail lowers err", {7'd0, err_o}, 8'd0);
    tick(); tick(); tick();
    chk("R4 err sticky", {7'd0, err_o}, 8'd0);
    pulse_clr();
    chk("R5 clear restores err", {7'd0, err_o}, 8'd1);
    fail_i[1] = 1'b1; cmd_err_clr = 1'b1; tick(); fail_i = '0; cmd_err_clr = 1'b0;
    chk("R5 fail beats clear", {7'd0, err_o}, 8'd0);
    pulse_clr();
    chk("R5 second clear", {7'd0, err_o}, 8'd1);
  endtask

  task automatic t_plain_reset();
    pulse_fail(1);
    chip_rst = 1'b1; #1;
    chk("R9 active during chip reset", {7'd0, jtag_active}, 8'd1);
    tick(); chip_rst = 1'b0;
    chk("R6 unarmed reset keeps err low", {7'd0, err_o}, 8'd0);
    chk("R9 pins still enabled", {7'd0, err_oe}, 8'd1);
  endtask

  task automatic t_isc_release();
    pulse_isc();
    chk("R7 armed, flag still low", {7'd0, err_o}, 8'd0);
    pulse_rst();
    chk("R7 reset after isc releases err", {7'd0, err_o}, 8'd1);
    pulse_fail(0);
    pulse_rst();
    chk("R7 arming consumed", {7'd0, err_o}, 8'd0);
    pulse_clr();
  endtask

  task automatic t_open_drain();
    set_drv(1'b1);
    chk("R8 open-drain idle floats", pins(), 8'h0);
    pulse_fail(0);
    chk("R8 open-drain err pulls low", pins(), 8'b0010);
    busy_i = 3'b100; tick();
    chk("R8 open-drain both low", pins(), 8'b1010);
    busy_i = '0;
    set_drv(1'b0);
    chk("R8 back to push-pull", pins(), 8'b1110);
    pulse_clr();
    set_drv(1'b1);
  endtask

  task automatic t_reg_mode();
    pin_src_nvm = 1'b0; jtag_reg_en = 1'b0; #1;
    chk("R10 inactive with reg bit 0", {7'd0, jtag_active}, 8'd0);
    jtag_reg_en = 1'b1; #1;
    chk("R10 active with reg bit 1", {7'd0, jtag_active}, 8'd1);
    pulse_fail(1);
    chip_rst = 1'b1; cmd_ext_on = 1'b1; #1;
    chk("R10 reset blocks activity", {7'd0, jtag_active}, 8'd0);
    tick(); chip_rst = 1'b0; cmd_ext_on = 1'b0;
    chk("R10 reset wipes pin enable", pins(), 8'h0);
    jtag_reg_en = 1'b0;
    pulse_ext();
    chk("R11 ignored while inactive", pins(), 8'h0);
    jtag_reg_en = 1'b1;
    pulse_ext();
    chk("R10 drive mode wiped to push-pull, err kept", pins(), 8'b1110);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_status();
    t_error();
    t_plain_reset();
    t_isc_release();
    t_open_drain();
    t_reg_mode();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule